// File: doc/BRIEF.md
# Programmable Test Clock Generator

This block produces the serial test clock for a boundary-scan bus from a faster system clock. It also produces one-cycle strobes that mark each rising and each falling test-clock edge. The sequencer and the serial data path use these strobes in place of the test clock itself: they shift outgoing bits on a falling strobe and capture incoming bits on a rising strobe. All logic runs in the system clock domain.

A two-bit mode input selects one of four behaviours:
- **Free-running.** The clock toggles all the time.
- **Gated.** The clock runs only while the sequencer reports that a state move, run-test or scan is in progress.
- **Discrete.** Each host write sets the clock level directly.
- **Parked.** The clock is held low.

In free-running and gated modes, the divide value sets how many system clocks each half period lasts. An external enable passes straight through to the bus-output enable, so another controller can take over the bus.

Top module: `tck_gen`

## Requirements
- R1: While reset is asserted, and on release, `tck`, `rise_stb` and `fall_stb` are all 0.
- R2: With `mode` = 2'b00 (free-running) and divide value N ≥ 1, `tck` first rises on the N-th system clock edge after reset release. After that it toggles every N edges, giving a period of 2N and a 50% duty cycle.
- R3: A divide value of 0 behaves exactly like a divide value of 1.
- R4: `rise_stb` is high for exactly the one cycle in which `tck` has just become 1. `fall_stb` is high for exactly the one cycle in which `tck` has just become 0. The two strobes are never high together.
- R5: With `mode` = 2'b01 (gated), while `busy` is 0 and `tck` is low, `tck` stays low and no strobe occurs.
- R6: In gated mode the clock only starts from low. When `busy` rises, the first rise comes N edges after `busy` is first seen. If `busy` drops while `tck` is high, the high phase still lasts its full N cycles, ends with a falling strobe, and the clock then stops low.
- R7: With `mode` = 2'b10 (discrete), an edge with `host_wr` = 1 loads `host_lvl` into `tck`, and a strobe fires only if the level changes. Without a write, `tck` holds. In every other mode, host writes have no effect.
- R8: With `mode` = 2'b11 (parked), `tck` is driven low on the next edge. A falling strobe fires if it was high. It then stays low with no strobes.
- R9: `bus_oe` equals `out_en` at all times.
- R10: A new divide value applies from the next toggle. If the current phase has already lasted at least the new half period, `tck` toggles on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 free-running, 01 gated, 10 discrete, 11 parked |
| div | input | DIV_W | Half-period length in system clocks (0 behaves as 1) |
| busy | input | 1 | Sequencer requests clock activity (gated mode) |
| host_wr | input | 1 | Host write strobe for discrete mode |
| host_lvl | input | 1 | Level written to the test clock in discrete mode |
| out_en | input | 1 | External enable for the bus drivers |
| tck | output | 1 | Test clock |
| rise_stb | output | 1 | One-cycle strobe after a rising test-clock edge |
| fall_stb | output | 1 | One-cycle strobe after a falling test-clock edge |
| bus_oe | output | 1 | Bus-output enable, follows `out_en` |

## Verification
Two events can fall in the same cycle in gated mode:
- the sequencer withdrawing `busy`, and
- the divider finishing a high phase.

The bench provokes this by dropping `busy` so that the clock edge which first sees it low is the same edge on which the high phase expires. The expected result is a single falling strobe on that edge, followed by a quiet low clock with no extra pulse. The bench also drops `busy` right after a rise, and checks that the high phase still lasts its full length.

// File: rtl/tck_gen.sv
module tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] div,
  input  logic             busy,
  input  logic             host_wr,
  input  logic             host_lvl,
  input  logic             out_en,
  output logic             tck,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             bus_oe
);
  localparam logic [1:0] M_FREE = 2'b00;
  localparam logic [1:0] M_GATE = 2'b01;
  localparam logic [1:0] M_DISC = 2'b10;
  localparam logic [1:0] M_PARK = 2'b11;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic             run;
  logic             last;
  logic             nxt;

  assign half   = (div == '0) ? DIV_W'(1) : div;
  assign last   = cnt >= (half - DIV_W'(1));
  assign run    = (mode == M_FREE) || ((mode == M_GATE) && (busy || tck));
  assign bus_oe = out_en;

  always_comb begin
    nxt = tck;
    case (mode)
      M_FREE, M_GATE: if (run && last) nxt = ~tck;
      M_DISC:         if (host_wr) nxt = host_lvl;
      default:        nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      tck      <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      cnt      <= (run && !last) ? cnt + 1'b1 : '0;
      tck      <= nxt;
      rise_stb <= nxt & ~tck;
      fall_stb <= ~nxt & tck;
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  // R4
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (tck && !$past(tck)));

  // R4
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!tck && $past(tck)));

  // R5
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_GATE && !busy && !tck) |=> (!tck && !rise_stb));

  // R7
  disc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DISC && !host_wr) |=> $stable(tck));

  // R8
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PARK) |=> (!tck && !rise_stb));
endmodule

// File: tb/tck_gen_tb_top.sv
`timescale 1ns/1ps
module tck_gen_tb_top;
  localparam int DIV_W = 8;
  localparam int NV = 5;
  localparam int DIVS [NV] = '{1, 2, 3, 5, 0};
  localparam int HALFS[NV] = '{1, 2, 3, 5, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [DIV_W-1:0] div = '0;
  logic busy = 1'b0, host_wr = 1'b0, host_lvl = 1'b0, out_en = 1'b0;
  logic tck, rise_stb, fall_stb, bus_oe;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  tck_gen #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .div(div), .busy(busy),
    .host_wr(host_wr), .host_lvl(host_lvl), .out_en(out_en),
    .tck(tck), .rise_stb(rise_stb), .fall_stb(fall_stb), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; busy = 1'b0; host_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int pins();
    return {29'd0, tck, rise_stb, fall_stb};
  endfunction

  task automatic quiet(input int n, input string req);
    bit bad = 0;
    int act = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pins() != 0 && !bad) begin bad = 1; act = pins(); end
    end
    chk(!bad, req, act, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(pins() == 0, "R1", pins(), 0);
    rst_n = 1'b1;

    // R9 enable passthrough
    out_en = 1'b1; #1;
    chk(bus_oe == 1'b1, "R9", bus_oe, 1);
    out_en = 1'b0; #1;
    chk(bus_oe == 1'b0, "R9", bus_oe, 0);

    // R2 / R3: free-running table
    for (int v = 0; v < NV; v++) begin
      bit bad = 0;
      int act = 0, exp = 0;
      mode = 2'b00;
      div = DIV_W'(DIVS[v]);
      do_reset();
      for (int c = 1; c <= 6 * HALFS[v]; c++) begin
        int ph, e;
        @(negedge clk);
        ph = c / HALFS[v];
        e = ((ph % 2) << 2)
          | (((c % HALFS[v] == 0) && (ph % 2 == 1)) ? 2 : 0)
          | (((c % HALFS[v] == 0) && (ph % 2 == 0)) ? 1 : 0);
        if (pins() != e && !bad) begin bad = 1; act = pins(); exp = e; end
      end
      chk(!bad, (DIVS[v] == 0) ? "R3" : "R2", act, exp);
    end

    // R10 divide change mid-phase
    mode = 2'b00; div = 8'd5;
    do_reset();
    repeat (7) @(negedge clk);
    div = 8'd2;
    @(negedge clk);
    chk(pins() == 1, "R10", pins(), 1);
    repeat (2) @(negedge clk);
    chk(pins() == 6, "R10", pins(), 6);

    // R5 gated idle, R7 write ignored outside discrete
    mode = 2'b01; div = 8'd3;
    do_reset();
    quiet(8, "R5");
    host_wr = 1'b1; host_lvl = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk(pins() == 0, "R7", pins(), 0);
    quiet(6, "R5");

    // R6 burst ending exactly on a falling edge
    busy = 1'b1;
    repeat (2) @(negedge clk);
    chk(tck == 1'b0, "R6", tck, 0);
    @(negedge clk);
    chk(pins() == 6, "R6", pins(), 6);
    repeat (2) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    chk(pins() == 1, "R6", pins(), 1);
    quiet(10, "R6");

    // R6 busy withdrawn right after a rise
    busy = 1'b1;
    repeat (3) @(negedge clk);
    chk(pins() == 6, "R6", pins(), 6);
    busy = 1'b0;
    repeat (2) @(negedge clk);
    chk(pins() == 4, "R6", pins(), 4);
    @(negedge clk);
    chk(pins() == 1, "R6", pins(), 1);
    quiet(8, "R6");

    // R7 discrete mode
    mode = 2'b10;
    host_wr = 1'b1; host_lvl = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk(pins() == 6, "R7", pins(), 6);
    @(negedge clk);
    chk(pins() == 4, "R7", pins(), 4);
    host_wr = 1'b1; host_lvl = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk(pins() == 4, "R7", pins(), 4);
    repeat (6) @(negedge clk);
    chk(pins() == 4, "R7", pins(), 4);
    host_wr = 1'b1; host_lvl = 1'b0;
    @(negedge clk);
    host_wr = 1'b0;
    chk(pins() == 1, "R7", pins(), 1);
    host_wr = 1'b1; host_lvl = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk(pins() == 6, "R7", pins(), 6);

    // R8 park from high
    mode = 2'b11;
    @(negedge clk);
    chk(pins() == 1, "R8", pins(), 1);
    host_wr = 1'b1; host_lvl = 1'b1;
    quiet(6, "R8");
    host_wr = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule